// File: doc/BRIEF.md
# VC-4 Path Overhead Monitor

This block sits after pointer processing in a high-order path receiver. It is given the VC-4 byte stream with a marker on the first path overhead byte (J1) and a flag on every byte of the overhead column. It picks out the nine overhead bytes of each frame and keeps the latest copy of each in a small register file that a host can read. It also puts each overhead byte on a side port as it arrives.

Two error sources are counted. The first is the B3 parity check: an even BIP-8 is computed over the whole of one VC-4, and the result is compared with the B3 byte that arrives in the next frame. The second is the far-end error count carried in the upper nibble of G1. Both counters run in one of two modes. In bit mode every errored bit is added. In block mode each errored frame adds one. The remote defect indication bit of G1 passes through a persistence filter before it drives an alarm. The counters are 16 bits wide, stop at full scale, and clear when the host reads them.

Top module: `vc4_poh_monitor`

## Requirements
- R1: The overhead bytes at overhead positions 0 to 8 of a frame are stored at host addresses 0 to 8, where J1 is position 0, B3 is position 1 and G1 is position 3. A read returns the stored byte, zero-extended, on `host_data_o` one clock after `host_rd_i`. After reset every address reads zero.
- R2: One clock after each accepted overhead byte, `poh_vld_o` is high and `poh_idx_o` and `poh_data_o` carry that byte's position and value. At all other times `poh_vld_o` is low.
- R3: B3 is checked against the even BIP-8 of all valid bytes from a J1 up to the byte before the next J1. The B3 of the first frame after reset is not checked.
- R4: With `cfg_block_i` = 0, the B3 counter at address 9 grows by the number of bits in which the received B3 differs from the computed parity.
- R5: With `cfg_block_i` = 1, each frame with any B3 mismatch adds exactly one to the address 9 counter, and each frame with a nonzero valid far-end count adds exactly one to the address 10 counter.
- R6: The far-end count is G1 bits 7:4. Values 0 to 8 are added to the address 10 counter in bit mode. Values 9 to 15 add nothing.
- R7: `rdi_o` rises after 5 consecutive frames with G1 bit 3 set. It falls after 5 consecutive frames with that bit clear. Any frame of the opposite value restarts the run.
- R8: Both counters stop at 65535 and never wrap.
- R9: A host read of address 9 or 10 returns the counter value and clears that counter.
- R10: Bytes with `vld_i` low, and overhead-flagged bytes seen before the first J1 after reset, change neither the register file nor the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Byte on `data_i` is a VC-4 byte |
| j1_i | input | 1 | Byte is J1, the first overhead byte of a frame |
| poh_col_i | input | 1 | Byte lies in the path overhead column |
| data_i | input | 8 | VC-4 byte |
| cfg_block_i | input | 1 | 1 = block counting, 0 = bit counting |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | 4 | Host read address (0-8 bytes, 9 B3 count, 10 far-end count) |
| host_data_o | output | 16 | Host read data, one clock after the strobe |
| poh_vld_o | output | 1 | Overhead byte present on the side port |
| poh_idx_o | output | 4 | Overhead position of the side-port byte |
| poh_data_o | output | 8 | Overhead byte value |
| rdi_o | output | 1 | Filtered remote defect alarm |

## Verification
The assertions assume that J1 always arrives with `poh_col_i` high and `vld_i` high. They also assume that no more than nine flagged bytes follow a J1. From these assumptions they derive that the position index stays in range, that the alarm changes only on a G1 byte, and that the counters never step backwards except on a clear. The bench builds every frame with J1 first and exactly nine flagged bytes. It places idle cycles with junk data only on cycles where `vld_i` is low, and it changes `cfg_block_i` only between frames. A block-mode step therefore always comes from a single frame.

// File: rtl/vc4_poh_pkg.sv
package vc4_poh_pkg;

   localparam int POH_BYTES = 9;
   localparam int IDX_W     = 4;
   localparam int AMT_W     = 4;
   localparam int IDX_J1    = 0;
   localparam int IDX_B3    = 1;
   localparam int IDX_G1    = 3;
   localparam int FEBE_MAX  = 8;

   typedef struct packed {
      logic             vld;
      logic [AMT_W-1:0] amt;
   } err_evt_t;

   function automatic logic [AMT_W-1:0] ones8(input logic [7:0] b);
      logic [AMT_W-1:0] n;
      n = '0;
      for (int i = 0; i < 8; i++) n = n + {{(AMT_W-1){1'b0}}, b[i]};
      return n;
   endfunction

endpackage

// File: rtl/vc4_poh_locator.sv
module vc4_poh_locator
   import vc4_poh_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic             j1_i,
   input  logic             col_i,
   output logic             hit_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [IDX_W-1:0] NONE = IDX_W'(POH_BYTES);

   logic [IDX_W-1:0] next_q;
   logic             past_ok;

   always_comb begin
      idx_o = j1_i ? '0 : next_q;
      hit_o = vld_i && (j1_i || (col_i && (next_q < NONE)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_q  <= NONE;
         past_ok <= 1'b0;
      end else begin
         past_ok <= 1'b1;
         if (hit_o) next_q <= idx_o + 1'b1;
      end
   end

   // R10: no position is tracked before the first J1
   a_r10_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      next_q <= NONE);

   a_r1_j1_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && j1_i) |=> (next_q == IDX_W'(1)));

endmodule

// File: rtl/vc4_b3_check.sv
module vc4_b3_check
   import vc4_poh_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vld_i,
   input  logic       j1_i,
   input  logic       b3_hit_i,
   input  logic [7:0] data_i,
   output err_evt_t   evt_o
);

   logic [7:0] acc_q;
   logic [7:0] ref_q;
   logic       seen_q;
   logic       have_ref_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q      <= '0;
         ref_q      <= '0;
         seen_q     <= 1'b0;
         have_ref_q <= 1'b0;
         evt_o      <= '0;
      end else begin
         if (vld_i && j1_i) begin
            ref_q      <= acc_q;
            have_ref_q <= seen_q;
            acc_q      <= data_i;
            seen_q     <= 1'b1;
         end else if (vld_i && seen_q) begin
            acc_q <= acc_q ^ data_i;
         end
         evt_o.vld <= b3_hit_i && have_ref_q;
         evt_o.amt <= ones8(data_i ^ ref_q);
      end
   end

   // R3: nothing is reported until one full frame has been seen
   a_r3_first_frame_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !have_ref_q |-> !evt_o.vld);

   a_r4_amt_range: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o.vld |-> (evt_o.amt <= AMT_W'(8)));

endmodule

// File: rtl/vc4_g1_monitor.sv
module vc4_g1_monitor
   import vc4_poh_pkg::*;
#(
   parameter int RDI_FRAMES = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             g1_hit_i,
   input  logic [AMT_W-1:0] febe_i,
   input  logic             rdi_bit_i,
   output err_evt_t         evt_o,
   output logic             rdi_o
);

   localparam int RUN_W = $clog2(RDI_FRAMES + 1);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RDI_FRAMES - 1);

   generate
      if (RDI_FRAMES < 1) begin : g_bad_frames
         $error("RDI_FRAMES must be at least 1");
      end
   endgenerate

   logic [RUN_W-1:0] run_q;
   logic             past_ok;
   logic [AMT_W-1:0] febe_ok;

   always_comb febe_ok = (febe_i > AMT_W'(FEBE_MAX)) ? '0 : febe_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= '0;
         rdi_o   <= 1'b0;
         evt_o   <= '0;
         past_ok <= 1'b0;
      end else begin
         past_ok   <= 1'b1;
         evt_o.vld <= g1_hit_i;
         evt_o.amt <= febe_ok;
         if (g1_hit_i) begin
            if (rdi_bit_i != rdi_o) begin
               if (run_q == RUN_LAST) begin
                  rdi_o <= rdi_bit_i;
                  run_q <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end else begin
               run_q <= '0;
            end
         end
      end
   end

   a_r6_febe_range: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o.vld |-> (evt_o.amt <= AMT_W'(FEBE_MAX)));

   a_r7_rdi_only_on_g1: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(g1_hit_i)) |-> $stable(rdi_o));

   a_r7_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_LAST);

endmodule

// File: rtl/vc4_err_counter.sv
module vc4_err_counter
   import vc4_poh_pkg::*;
#(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             block_i,
   input  err_evt_t         evt_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] base;
   logic [AMT_W-1:0] step;
   logic [CNT_W:0]   sum;
   logic             past_ok;

   always_comb begin
      if (!evt_i.vld)   step = '0;
      else if (block_i) step = {{(AMT_W-1){1'b0}}, (evt_i.amt != '0)};
      else              step = evt_i.amt;
      base = clr_i ? '0 : cnt_o;
      sum  = {1'b0, base} + (CNT_W+1)'(step);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_o   <= '0;
         past_ok <= 1'b0;
      end else begin
         past_ok <= 1'b1;
         cnt_o   <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      end
   end

   a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(clr_i)) |-> (cnt_o >= $past(cnt_o)));

   a_r5_block_step: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(block_i) && !$past(clr_i)) |-> ((cnt_o - $past(cnt_o)) <= CNT_W'(1)));

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(clr_i) && !$past(evt_i.vld)) |-> (cnt_o == '0));

endmodule

// File: rtl/vc4_poh_monitor.sv
module vc4_poh_monitor
   import vc4_poh_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int RDI_FRAMES = 5,
   parameter int ADDR_W     = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic              j1_i,
   input  logic              poh_col_i,
   input  logic [7:0]        data_i,
   input  logic              cfg_block_i,
   input  logic              host_rd_i,
   input  logic [ADDR_W-1:0] host_addr_i,
   output logic [CNT_W-1:0]  host_data_o,
   output logic              poh_vld_o,
   output logic [IDX_W-1:0]  poh_idx_o,
   output logic [7:0]        poh_data_o,
   output logic              rdi_o
);

   localparam int N_CNT = 2;

   generate
      if (CNT_W < 8) begin : g_bad_cnt
         $error("CNT_W must hold a full byte");
      end
      if ((1 << ADDR_W) < POH_BYTES + N_CNT) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic             hit;
   logic [IDX_W-1:0] idx;
   logic [7:0]       poh_q [POH_BYTES];
   err_evt_t         evt [N_CNT];
   logic [CNT_W-1:0] cnt [N_CNT];
   logic [CNT_W-1:0] rd_mux;
   logic             past_ok;

   vc4_poh_locator u_loc (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (vld_i),
      .j1_i  (j1_i),
      .col_i (poh_col_i),
      .hit_o (hit),
      .idx_o (idx)
   );

   vc4_b3_check u_b3 (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld_i    (vld_i),
      .j1_i     (j1_i),
      .b3_hit_i (hit && (idx == IDX_W'(IDX_B3))),
      .data_i   (data_i),
      .evt_o    (evt[0])
   );

   vc4_g1_monitor #(.RDI_FRAMES(RDI_FRAMES)) u_g1 (
      .clk       (clk),
      .rst_n     (rst_n),
      .g1_hit_i  (hit && (idx == IDX_W'(IDX_G1))),
      .febe_i    (data_i[7:4]),
      .rdi_bit_i (data_i[3]),
      .evt_o     (evt[1]),
      .rdi_o     (rdi_o)
   );

   genvar k;
   generate
      for (k = 0; k < N_CNT; k++) begin : g_cnt
         vc4_err_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .block_i (cfg_block_i),
            .evt_i   (evt[k]),
            .clr_i   (host_rd_i && (host_addr_i == ADDR_W'(POH_BYTES + k))),
            .cnt_o   (cnt[k])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < POH_BYTES; i++) poh_q[i] <= '0;
         poh_vld_o <= 1'b0;
         poh_idx_o <= '0;
         poh_data_o <= '0;
         past_ok <= 1'b0;
      end else begin
         past_ok   <= 1'b1;
         poh_vld_o <= hit;
         if (hit) begin
            poh_idx_o  <= idx;
            poh_data_o <= data_i;
         end
         for (int i = 0; i < POH_BYTES; i++)
            if (hit && (idx == IDX_W'(i))) poh_q[i] <= data_i;
      end
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < POH_BYTES; i++)
         if (host_addr_i == ADDR_W'(i)) rd_mux = {{(CNT_W-8){1'b0}}, poh_q[i]};
      for (int c = 0; c < N_CNT; c++)
         if (host_addr_i == ADDR_W'(POH_BYTES + c)) rd_mux = cnt[c];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         host_data_o <= '0;
      else if (host_rd_i) host_data_o <= rd_mux;
   end

   a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      poh_vld_o |-> (poh_idx_o < IDX_W'(POH_BYTES)));

   a_r1_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(host_rd_i)) |-> $stable(host_data_o));

endmodule

// File: tb/sim_vc4_poh_monitor.sv
module sim_vc4_poh_monitor;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld_i = 1'b0, j1_i = 1'b0, poh_col_i = 1'b0, cfg_block_i = 1'b0;
   logic [7:0]  data_i = '0;
   logic        host_rd_i = 1'b0;
   logic [3:0]  host_addr_i = '0;
   logic [15:0] host_data_o;
   logic        poh_vld_o;
   logic [3:0]  poh_idx_o;
   logic [7:0]  poh_data_o;
   logic        rdi_o;

   always #10 clk = ~clk;

   vc4_poh_monitor u0 (.*);

   int total = 0, bad = 0, r2_bad = 0, fnum = 0;
   bit done = 1'b0;
   logic [7:0] cur_bip = '0, prev_bip = '0;
   logic [7:0] exp_poh [9];

   // {mask, g1, block, exp_b3, exp_febe}
   localparam logic [24:0] VEC [8] = '{
      {8'h00, 8'h00, 1'b0, 4'd0, 4'd0},
      {8'h01, 8'h10, 1'b0, 4'd1, 4'd1},
      {8'hFF, 8'h80, 1'b0, 4'd8, 4'd8},
      {8'h0F, 8'h90, 1'b0, 4'd4, 4'd0},
      {8'h0F, 8'h30, 1'b1, 4'd1, 4'd1},
      {8'h00, 8'hF0, 1'b1, 4'd0, 4'd0},
      {8'hA5, 8'h50, 1'b0, 4'd4, 4'd5},
      {8'h80, 8'h00, 1'b1, 4'd1, 4'd0}
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input logic j1, input logic col, input int idx);
      vld_i = 1'b1; j1_i = j1; poh_col_i = col; data_i = b;
      if (j1) begin prev_bip = cur_bip; cur_bip = b; end
      else cur_bip = cur_bip ^ b;
      @(negedge clk);
      vld_i = 1'b0; j1_i = 1'b0; poh_col_i = 1'b0;
      if (col && fnum > 0) begin
         if (!poh_vld_o || poh_idx_o != 4'(idx) || poh_data_o != b) r2_bad++;
      end else if (poh_vld_o) r2_bad++;
   endtask

   task automatic idle_junk();
      vld_i = 1'b0; poh_col_i = 1'b1; data_i = 8'h5A ^ 8'(fnum);
      @(negedge clk);
      poh_col_i = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] mask, input logic [7:0] g1, input int ndata);
      fnum++;
      exp_poh[0] = 8'h20 ^ 8'(fnum);
      exp_poh[2] = 8'h13;
      exp_poh[3] = g1;
      for (int i = 4; i < 9; i++) exp_poh[i] = 8'(8'h40 + i) ^ 8'(fnum * 3);
      send_byte(exp_poh[0], 1'b1, 1'b1, 0);
      if (ndata > 0) idle_junk();
      exp_poh[1] = cur_bip ^ mask; // placeholder, fixed below
      exp_poh[1] = prev_bip ^ mask;
      for (int i = 1; i < 9; i++) begin
         send_byte(exp_poh[i], 1'b0, 1'b1, i);
         for (int d = 0; d < ndata; d++) send_byte(8'(d * 37 + i * 11 + fnum), 1'b0, 1'b0, 0);
      end
   endtask

   task automatic host_read(input logic [3:0] a, output int v);
      host_rd_i = 1'b1; host_addr_i = a;
      @(negedge clk);
      host_rd_i = 1'b0;
      v = int'(host_data_o);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset host_data", int'(host_data_o), 0);
      chk("R2 reset poh_vld", int'(poh_vld_o), 0);
      chk("R7 reset rdi", int'(rdi_o), 0);
      host_read(4'd3, v); chk("R1 reset addr3", v, 0);

      // R10: flagged bytes before any J1 are ignored
      for (int i = 0; i < 5; i++) begin
         vld_i = 1'b1; poh_col_i = 1'b1; data_i = 8'h77;
         @(negedge clk);
         chk("R10 no side output before J1", int'(poh_vld_o), 0);
      end
      vld_i = 1'b0; poh_col_i = 1'b0;
      host_read(4'd0, v); chk("R10 addr0 untouched", v, 0);

      // R3: first frame is not checked even with a wrong B3
      send_frame(8'hFF, 8'h00, 2);
      @(negedge clk);
      host_read(4'd9, v); chk("R3 first frame unchecked", v, 0);

      // vector table
      foreach (VEC[n]) begin
         cfg_block_i = VEC[n][8];
         @(negedge clk);
         send_frame(VEC[n][24:17], VEC[n][16:9], 3);
         @(negedge clk);
         host_read(4'd9, v);
         chk(VEC[n][8] ? "R5 B3 block" : "R4 B3 bits", v, int'(VEC[n][7:4]));
         host_read(4'd10, v);
         chk(VEC[n][8] ? "R5 far-end block" : "R6 far-end bits", v, int'(VEC[n][3:0]));
      end
      cfg_block_i = 1'b0;
      // R9: counters cleared by the reads above
      host_read(4'd9, v); chk("R9 B3 cleared", v, 0);
      host_read(4'd10, v); chk("R9 far-end cleared", v, 0);

      // R1: stored overhead bytes of the last frame (junk idle cycles ignored, R10)
      for (int i = 0; i < 9; i++) begin
         host_read(4'(i), v);
         chk("R1 stored byte", v, int'(exp_poh[i]));
      end

      // R7 RDI persistence
      for (int i = 0; i < 4; i++) send_frame(8'h00, 8'h08, 0);
      chk("R7 not yet after 4", int'(rdi_o), 0);
      send_frame(8'h00, 8'h08, 0);
      chk("R7 set after 5", int'(rdi_o), 1);
      send_frame(8'h00, 8'h00, 0);
      for (int i = 0; i < 3; i++) send_frame(8'h00, 8'h08, 0);
      for (int i = 0; i < 4; i++) send_frame(8'h00, 8'h00, 0);
      chk("R7 held after broken run and 4 clear", int'(rdi_o), 1);
      send_frame(8'h00, 8'h00, 0);
      chk("R7 cleared after 5", int'(rdi_o), 0);
      for (int i = 0; i < 3; i++) send_frame(8'h00, 8'h08, 0);
      send_frame(8'h00, 8'h00, 0);
      for (int i = 0; i < 4; i++) send_frame(8'h00, 8'h08, 0);
      chk("R7 run restarted", int'(rdi_o), 0);

      // R8 saturation
      host_read(4'd9, v); host_read(4'd10, v);
      for (int i = 0; i < 8200; i++) send_frame(8'hFF, 8'h80, 0);
      @(negedge clk);
      host_read(4'd9, v); chk("R8 B3 saturates", v, 65535);
      host_read(4'd10, v); chk("R8 far-end saturates", v, 65535);
      host_read(4'd9, v); chk("R9 cleared after saturation", v, 0);

      chk("R2 side port mismatches", r2_bad, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule